// File: doc/BRIEF.md
# Transmit Descriptor Chain Walker

This block is the transmit-side DMA sequencer of an Ethernet MAC. Software builds a linked chain of 16-byte descriptors in memory, hands each one to the MAC by setting its ownership bit, and then pulses a start demand that carries the address of the first descriptor. The walker reads each descriptor one word at a time and checks who owns it. For a MAC-owned descriptor it presents a frame request with the buffer address, the length and the CRC-append choice. Once the frame is reported sent, it writes completion status back into the descriptor and returns ownership to software. It then follows the next pointer.

The walk stops at the first descriptor that software still owns. At that point the walker raises a descriptor-unavailable status bit. Completion and per-frame interrupt status bits collect in a small write-one-to-clear register, and a single interrupt line reflects the enabled bits. The payload byte mover and the PHY side are not part of this block: a request/done handshake stands in for them. Memory is reached through a word-wide request port that holds each request until it is acknowledged.

Top module: `txdesc_walker`

## Requirements
- R1: After reset, `active`, `mem_req`, `frame_req`, `irq` and all of `int_status` are 0.
- R2: A `start` pulse while idle and `tx_en` is 1 makes `active` 1 on the next cycle, loads `cur_desc` with `start_addr` with its low 2 bits cleared, and issues the first read at that address.
- R3: A descriptor is read as four words at offsets 0 (control), 4 (buffer address), 8 (status/length) and 12 (next pointer). A request stays asserted with a stable address until `mem_ack`. Control bit 31 set means the MAC owns the descriptor.
- R4: On reading a control word with bit 31 clear, the walker sets `int_status[2]` (descriptor unavailable), returns to idle and issues no frame request. While idle it issues no memory or frame request.
- R5: The frame request carries `frame_addr` = buffer word with its low 2 bits cleared and `frame_crc` = control bit 1. `frame_len` is the low 16 bits of the status/length word, raised to MIN_LEN when control bit 0 is set and the length is below MIN_LEN. These stay stable until `frame_done`.
- R6: After `frame_done`, the walker writes offset 8 with the original 16-bit length in bits 15:0, bit 19 set, bit 16 equal to control bit 2, and all other bits 0. It then writes offset 0 with the control word with bit 31 cleared and all other bits unchanged.
- R7: Each completed descriptor sets `int_status[1]` (complete). When its control bit 2 is set, it also sets `int_status[0]` (frame interrupt).
- R8: After a descriptor completes, `cur_desc` becomes its next pointer with the low 2 bits cleared, and processing continues there. `cur_buf` shows the last buffer address read.
- R9: When `tx_en` is 0, `active` is 0 on the next cycle and a `start` pulse is ignored.
- R10: `irq` is 1 exactly when some bit of `int_status & int_en` is 1.
- R11: A 1 on bit i of `int_clr` clears `int_status[i]` and leaves the other bits unchanged.
- R12: A `soft_rst` cycle returns the walker to idle and clears `int_status` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | Software reset: idle and clear status |
| tx_en | input | 1 | Transmit enable; 0 forces idle |
| start | input | 1 | Start-demand pulse |
| start_addr | input | AW | First descriptor address |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request accepted / read data valid |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| frame_req | output | 1 | Frame send request |
| frame_addr | output | AW | Frame buffer address |
| frame_len | output | 16 | Frame length in bytes after padding |
| frame_crc | output | 1 | Append CRC |
| frame_done | input | 1 | Frame sent |
| int_en | input | 3 | Interrupt enables for int_status |
| int_clr | input | 3 | Write-one-to-clear strobes |
| int_status | output | 3 | [0] frame interrupt, [1] complete, [2] unavailable |
| irq | output | 1 | Interrupt line |
| active | output | 1 | Walker running |
| cur_desc | output | AW | Current descriptor address |
| cur_buf | output | AW | Current buffer address |

## Verification
The bench uses the defaults AW = 32 and MIN_LEN = 64. It runs chains of twelve descriptors. Together they cover all eight combinations of the pad, CRC and interrupt control bits, each combined with lengths of 0, 1, MIN_LEN-1, MIN_LEN, MIN_LEN+1 and 1500. This exercises both sides of the pad threshold and the masking of misaligned buffer, next and start addresses. Because the memory is small, every write-back word can be compared against its computed value. The bench also sweeps all eight enable masks against the collected status.

// File: rtl/txw_pkg.sv
package txw_pkg;

    localparam int WORD_W = 32;
    localparam int LEN_W  = 16;

    // control word bit positions
    localparam int CTL_OWN = 31;
    localparam int CTL_INT = 2;
    localparam int CTL_CRC = 1;
    localparam int CTL_PAD = 0;

    // write-back status bit positions
    localparam int WB_DONE = 19;
    localparam int WB_INT  = 16;

    // interrupt status indices
    localparam int IS_FRM   = 0;
    localparam int IS_CMP   = 1;
    localparam int IS_UNAV  = 2;
    localparam int IS_W     = 3;

    typedef enum logic [2:0] {
        W_IDLE, W_CTL, W_BUF, W_LEN, W_NXT, W_SEND, W_WSTAT, W_WCTL
    } walk_state_t;

    typedef struct packed {
        logic [WORD_W-1:0] ctl;
        logic [WORD_W-1:0] lenw;
    } desc_words_t;

    function automatic logic [LEN_W-1:0] padded_len(
        input logic [LEN_W-1:0] raw, input logic pad_on, input int unsigned min_len);
        if (pad_on && (32'(raw) < min_len))
            return LEN_W'(min_len);
        return raw;
    endfunction

    function automatic logic [WORD_W-1:0] wb_word(input logic [WORD_W-1:0] lenw, input logic want_int);
        logic [WORD_W-1:0] w;
        w = '0;
        w[LEN_W-1:0] = lenw[LEN_W-1:0];
        w[WB_DONE] = 1'b1;
        w[WB_INT]  = want_int;
        return w;
    endfunction

endpackage

// File: rtl/txw_len_calc.sv
module txw_len_calc
    import txw_pkg::*;
#(
    parameter int MIN_LEN = 64
) (
    input  logic [WORD_W-1:0] ctl,
    input  logic [WORD_W-1:0] lenw,
    output logic [LEN_W-1:0]  len_out,
    output logic              crc_out,
    output logic [WORD_W-1:0] status_out,
    output logic [WORD_W-1:0] ctl_back
);
    always_comb begin
        len_out    = padded_len(lenw[LEN_W-1:0], ctl[CTL_PAD], MIN_LEN);
        crc_out    = ctl[CTL_CRC];
        status_out = wb_word(lenw, ctl[CTL_INT]);
        ctl_back   = ctl;
        ctl_back[CTL_OWN] = 1'b0;
    end
endmodule

// File: rtl/txw_int_status.sv
module txw_int_status
    import txw_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            clear_all,
    input  logic [IS_W-1:0] set_bits,
    input  logic [IS_W-1:0] clr_bits,
    input  logic [IS_W-1:0] enables,
    output logic [IS_W-1:0] status,
    output logic            irq
);
    always_ff @(posedge clk) begin
        if (rst || clear_all)
            status <= '0;
        else
            status <= (status & ~clr_bits) | set_bits;
    end

    assign irq = |(status & enables);
endmodule

// File: rtl/txdesc_walker.sv
module txdesc_walker
    import txw_pkg::*;
#(
    parameter int AW      = 32,
    parameter int MIN_LEN = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst,
    input  logic              tx_en,
    input  logic              start,
    input  logic [AW-1:0]     start_addr,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              frame_req,
    output logic [AW-1:0]     frame_addr,
    output logic [LEN_W-1:0]  frame_len,
    output logic              frame_crc,
    input  logic              frame_done,
    input  logic [IS_W-1:0]   int_en,
    input  logic [IS_W-1:0]   int_clr,
    output logic [IS_W-1:0]   int_status,
    output logic              irq,
    output logic              active,
    output logic [AW-1:0]     cur_desc,
    output logic [AW-1:0]     cur_buf
);
    localparam logic [AW-1:0] ALIGN_MASK = ~AW'(3);
    localparam logic [AW-1:0] OFF_BUF    = AW'(4);
    localparam logic [AW-1:0] OFF_LEN    = AW'(8);
    localparam logic [AW-1:0] OFF_NXT    = AW'(12);

    walk_state_t      state;
    desc_words_t      dw;
    logic [AW-1:0]    nxt_ptr;
    logic [IS_W-1:0]  set_bits;
    logic [WORD_W-1:0] status_word, ctl_word;
    logic             halt;
    logic             acked;

    assign halt  = soft_rst || !tx_en;
    assign acked = mem_req && mem_ack;

    txw_len_calc #(.MIN_LEN(MIN_LEN)) u_len (
        .ctl        (dw.ctl),
        .lenw       (dw.lenw),
        .len_out    (frame_len),
        .crc_out    (frame_crc),
        .status_out (status_word),
        .ctl_back   (ctl_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= W_IDLE;
            dw       <= '0;
            nxt_ptr  <= '0;
            cur_desc <= '0;
            cur_buf  <= '0;
        end else if (halt) begin
            state <= W_IDLE;
        end else begin
            unique case (state)
                W_IDLE: if (start) begin
                    cur_desc <= start_addr & ALIGN_MASK;
                    state    <= W_CTL;
                end
                W_CTL: if (acked) begin
                    dw.ctl <= mem_rdata;
                    state  <= mem_rdata[CTL_OWN] ? W_BUF : W_IDLE;
                end
                W_BUF: if (acked) begin
                    cur_buf <= mem_rdata[AW-1:0] & ALIGN_MASK;
                    state   <= W_LEN;
                end
                W_LEN: if (acked) begin
                    dw.lenw <= mem_rdata;
                    state   <= W_NXT;
                end
                W_NXT: if (acked) begin
                    nxt_ptr <= mem_rdata[AW-1:0] & ALIGN_MASK;
                    state   <= W_SEND;
                end
                W_SEND:  if (frame_done) state <= W_WSTAT;
                W_WSTAT: if (acked) state <= W_WCTL;
                W_WCTL: if (acked) begin
                    cur_desc <= nxt_ptr;
                    state    <= W_CTL;
                end
                default: state <= W_IDLE;
            endcase
        end
    end

    always_comb begin
        set_bits = '0;
        if (!halt && acked) begin
            if (state == W_CTL && !mem_rdata[CTL_OWN])
                set_bits[IS_UNAV] = 1'b1;
            if (state == W_WCTL) begin
                set_bits[IS_CMP] = 1'b1;
                set_bits[IS_FRM] = dw.ctl[CTL_INT];
            end
        end
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cur_desc;
        mem_wdata = '0;
        unique case (state)
            W_CTL:   mem_req = 1'b1;
            W_BUF:   begin mem_req = 1'b1; mem_addr = cur_desc + OFF_BUF; end
            W_LEN:   begin mem_req = 1'b1; mem_addr = cur_desc + OFF_LEN; end
            W_NXT:   begin mem_req = 1'b1; mem_addr = cur_desc + OFF_NXT; end
            W_WSTAT: begin
                mem_req = 1'b1; mem_we = 1'b1;
                mem_addr = cur_desc + OFF_LEN; mem_wdata = status_word;
            end
            W_WCTL:  begin
                mem_req = 1'b1; mem_we = 1'b1; mem_wdata = ctl_word;
            end
            default: ;
        endcase
    end

    assign frame_req  = (state == W_SEND);
    assign frame_addr = cur_buf;
    assign active     = (state != W_IDLE);

    txw_int_status u_ints (
        .clk       (clk),
        .rst       (rst),
        .clear_all (soft_rst),
        .set_bits  (set_bits),
        .clr_bits  (int_clr),
        .enables   (int_en),
        .status    (int_status),
        .irq       (irq)
    );
endmodule

// File: rtl/txdesc_walker_checker.sv
module txdesc_walker_checker
    import txw_pkg::*;
#(
    parameter int AW = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             soft_rst,
    input logic             tx_en,
    input logic             active,
    input logic             mem_req,
    input logic             mem_ack,
    input logic [AW-1:0]    mem_addr,
    input logic             frame_req,
    input logic             frame_done,
    input logic [LEN_W-1:0] frame_len,
    input logic [IS_W-1:0]  int_en,
    input logic [IS_W-1:0]  int_status,
    input logic             irq
);
    assert_irq_mask_R10: assert property (@(posedge clk) disable iff (rst)
        irq == |(int_status & int_en));

    assert_disable_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !tx_en |=> !active);

    assert_softrst_clear_R12: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (!active && int_status == '0));

    assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        !active |-> (!mem_req && !frame_req));

    assert_req_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack && tx_en && !soft_rst) |=> (mem_req && $stable(mem_addr)));

    assert_frame_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (frame_req && !frame_done && tx_en && !soft_rst) |=> (frame_req && $stable(frame_len)));
endmodule

bind txdesc_walker txdesc_walker_checker #(.AW(AW)) u_chk (.*);

// File: tb/txdesc_walker_test.sv
module txdesc_walker_test;
    localparam int AW = 32;
    localparam int MIN_LEN = 64;
    localparam int PER_CHAIN = 12;
    localparam int CHAINS = 4;
    localparam logic [31:0] STOP_ADDR = 32'(16 * PER_CHAIN);

    logic clk = 0;
    always #2.5 clk = ~clk;

    logic rst = 1, soft_rst = 0, tx_en = 0, start = 0;
    logic [AW-1:0] start_addr = '0;
    logic mem_req, mem_we, mem_ack;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;
    logic frame_req, frame_crc;
    logic frame_done = 0;
    logic [AW-1:0] frame_addr;
    logic [15:0] frame_len;
    logic [2:0] int_en = 0, int_clr = 0, int_status;
    logic irq, active;
    logic [AW-1:0] cur_desc, cur_buf;

    txdesc_walker #(.AW(AW), .MIN_LEN(MIN_LEN)) uut (.*);

    logic [31:0] mem [64];
    logic tb_we = 0;
    logic [5:0] tb_a = 0;
    logic [31:0] tb_d = 0;

    assign mem_ack   = mem_req;
    assign mem_rdata = mem[mem_addr[7:2]];

    always @(posedge clk) begin
        if (tb_we) mem[tb_a] <= tb_d;
        else if (mem_req && mem_we) mem[mem_addr[7:2]] <= mem_wdata;
    end

    int tests = 0, fails = 0;
    int fr_tests = 0, fr_fails = 0, fk = 0;

    function automatic int len_of(int n);
        int lens[6] = '{0, 1, MIN_LEN-1, MIN_LEN, MIN_LEN+1, 1500};
        return lens[n % 6];
    endfunction
    function automatic logic [2:0] flg_of(int n); return 3'(n / 6); endfunction
    function automatic logic [31:0] buf_of(int n); return 32'h2000_0000 + 32'(n * 64) + 32'(n % 4); endfunction

    // frame handshake model and per-frame checks (R5)
    always @(negedge clk) begin
        if (frame_req && !frame_done) begin
            logic [2:0] f;
            int el;
            f  = flg_of(fk);
            el = (f[0] && len_of(fk) < MIN_LEN) ? MIN_LEN : len_of(fk);
            fr_tests++;
            if (frame_addr != (buf_of(fk) & ~32'd3) || frame_len != 16'(el) || frame_crc != f[1]) begin
                fr_fails++;
                $display("FAIL R5 frame %0d: addr=%h len=%0d crc=%b expected addr=%h len=%0d crc=%b",
                         fk, frame_addr, frame_len, frame_crc, buf_of(fk) & ~32'd3, el, f[1]);
            end
            fk++;
            frame_done <= 1'b1;
        end else begin
            frame_done <= 1'b0;
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int idx, input logic [31:0] d);
        tb_we = 1; tb_a = 6'(idx); tb_d = d;
        @(negedge clk);
        tb_we = 0;
    endtask

    task automatic build_chain(input int c);
        for (int j = 0; j < PER_CHAIN; j++) begin
            int n;
            n = c * PER_CHAIN + j;
            wr(4*j+0, 32'h8000_0A00 | 32'(flg_of(n)));
            wr(4*j+1, buf_of(n));
            wr(4*j+2, 32'h00F0_0000 | 32'(len_of(n)));
            wr(4*j+3, 32'(16*(j+1) + (j % 4)));
        end
        wr(4*PER_CHAIN, 32'h0000_0A00);
    endtask

    task automatic kick(input logic [31:0] a);
        start = 1; start_addr = a;
        @(negedge clk);
        start = 0;
    endtask

    task automatic wait_idle();
        int t;
        t = 0;
        while (active && t < 5000) begin @(negedge clk); t++; end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  [TB] %0d tests run, %0d failed", tests + fr_tests + 1, fails + fr_fails + 1);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check("R1 active", 64'(active), 0);
        check("R1 status", 64'(int_status), 0);
        check("R1 irq", 64'(irq), 0);
        check("R1 reqs", 64'({mem_req, frame_req}), 0);

        // R9: start ignored while disabled
        build_chain(0);
        kick(32'h0);
        check("R9 start ignored", 64'(active), 0);
        check("R9 no request", 64'(mem_req), 0);

        tx_en = 1;
        for (int c = 0; c < CHAINS; c++) begin
            logic [2:0] es;
            int fk0;
            build_chain(c);
            fk0 = fk;
            kick(32'(c % 4));
            // R2 start loads aligned address and reads it
            check("R2 active", 64'(active), 1);
            check("R2 cur_desc", 64'(cur_desc), 0);
            check("R2 first read", 64'({mem_req, mem_we, mem_addr}), 64'({2'b10, 32'h0}));
            wait_idle();
            check("R3/R4 stopped", 64'(active), 0);
            check("R3 frames seen", 64'(fk - fk0), PER_CHAIN);
            es = 3'b110;
            for (int j = 0; j < PER_CHAIN; j++) begin
                int n;
                logic [2:0] f;
                n = c * PER_CHAIN + j;
                f = flg_of(n);
                if (f[2]) es[0] = 1'b1;
                check("R6 status word", 64'(mem[4*j+2]),
                      64'(32'(len_of(n)) | 32'h0008_0000 | (f[2] ? 32'h0001_0000 : 32'h0)));
                check("R6 control handback", 64'(mem[4*j]), 64'(32'h0000_0A00 | 32'(f)));
            end
            check("R7/R4 status bits", 64'(int_status), 64'(es));
            check("R8 cur_desc at stop", 64'(cur_desc), 64'(STOP_ADDR));
            check("R8 cur_buf last", 64'(cur_buf), 64'(buf_of(c*PER_CHAIN + PER_CHAIN-1) & ~32'd3));
            for (int e = 0; e < 8; e++) begin
                int_en = 3'(e);
                @(negedge clk);
                check("R10 irq mask", 64'(irq), 64'(|(es & 3'(e))));
            end
            int_en = 0;
            // R11 clear complete bit only
            int_clr = 3'b010;
            @(negedge clk);
            int_clr = 0;
            check("R11 single clear", 64'(int_status), 64'(es & 3'b101));
            int_clr = 3'b111;
            @(negedge clk);
            int_clr = 0;
            check("R11 clear all", 64'(int_status), 0);
        end

        // R4: first descriptor CPU owned
        begin
            int fk0;
            fk0 = fk;
            kick(STOP_ADDR);
            @(negedge clk);
            check("R4 unavailable only", 64'({active, int_status}), 64'(4'b0100));
            check("R4 no frame", 64'(fk - fk0), 0);
            check("R4 cur_desc", 64'(cur_desc), 64'(STOP_ADDR));
        end

        // R12 soft reset clears status
        int_en = 3'b100;
        soft_rst = 1;
        @(negedge clk);
        soft_rst = 0;
        check("R12 status cleared", 64'(int_status), 0);
        check("R12 irq low", 64'(irq), 0);

        // R9 drop enable mid walk, R12 soft reset mid walk
        build_chain(0);
        kick(32'h0);
        @(negedge clk);
        tx_en = 0;
        @(negedge clk);
        check("R9 forced idle", 64'({active, mem_req}), 0);
        check("R9 descriptor untouched", 64'(mem[0]), 64'(32'h8000_0A00));
        tx_en = 1;
        fk = 0;
        kick(32'h0);
        @(negedge clk);
        soft_rst = 1;
        @(negedge clk);
        soft_rst = 0;
        check("R12 idle after soft reset", 64'({active, int_status}), 0);

        repeat (4) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", tests + fr_tests, fails + fr_fails);
        $finish;
    end
endmodule